// File: doc/BRIEF.md
# Aligned Interrupt Context Stacker

When an interrupt is taken, this block saves the processor's return context on the data stack. It stores the return address and the status word in one frame that always starts on a word boundary. An accept pulse samples the program counter, the 16-bit status word and the stack pointer. The block then makes two aligned 32-bit writes to a data memory port. It reports the lowered stack pointer together with a one-cycle completion strobe. The saved program counter is the address of the interrupted instruction, so that instruction runs again after the return.

The context takes 6 bytes, and the block pads it to an 8-byte frame. The stack pointer therefore stays a multiple of 4, and no access crosses a 32-bit boundary. Frame layout, from the lowest address:

| Byte offset | Contents |
|---|---|
| 0–1 | Status word |
| 2–3 | Reserved, written as zero |
| 4–7 | Program counter |

A return pulse runs the reverse sequence. It makes two aligned reads from the current stack pointer and outputs the saved program counter and status word. It also outputs the stack pointer raised by 8, which releases the frame. A stack pointer that is not a multiple of 4 stops either sequence before any memory access and raises an error strobe.

Top module: `irq_frame_stacker`

## Requirements
- R1: After a synchronous active-high reset, the block is idle. No write or read enable is asserted, and no done or error strobe is asserted.
- R2: In the cycle after an accepted interrupt, the block writes the word at address sp−8. Bits 15:0 of that word carry the status word and bits 31:16 are zero.
- R3: In the cycle after the first write, the block writes the program counter to address sp−4. The push makes exactly these two writes.
- R4: In the cycle after the second write, `push_done_o` is high for one cycle, and `sp_o` equals sp−8, a multiple of 4.
- R5: If the sampled stack pointer has bits 1:0 not equal to zero, `align_err_o` is high for one cycle in the next cycle. No write, no read and no done strobe follows.
- R6: After a return pulse, the block reads address sp in the next cycle and address sp+4 in the cycle after that, with `mem_re_o` high in both cycles.
- R7: In the cycle after the second read, `pop_done_o` is high for one cycle. `psw_o` then equals bits 15:0 of the first word read, `pc_o` equals the second word read, and `sp_o` equals sp+8.
- R8: An accept or return pulse that arrives while a sequence is running is ignored. After done, the block stays idle with no memory access.
- R9: If an accept pulse and a return pulse arrive in the same cycle, the push is performed.
- R10: Every memory access uses a word-aligned address, and a read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| accept_i | input | 1 | Interrupt accepted: push the context |
| reti_i | input | 1 | Return from interrupt: pop the context |
| pc_i | input | 32 | Return address to save |
| psw_i | input | 16 | Status word to save |
| sp_i | input | ADDR_W | Current stack pointer |
| mem_we_o | output | 1 | Memory write enable |
| mem_re_o | output | 1 | Memory read enable |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid in the same cycle as the read |
| push_done_o | output | 1 | Push complete (one cycle) |
| pop_done_o | output | 1 | Pop complete (one cycle) |
| align_err_o | output | 1 | Misaligned stack pointer (one cycle) |
| sp_o | output | ADDR_W | Updated stack pointer, valid with either done strobe |
| pc_o | output | 32 | Restored program counter |
| psw_o | output | 16 | Restored status word |

## Verification
The bench builds the block with the default 32-bit address width. The memory model decodes only the low 12 address bits, and the stack pointer is drawn from that range. This keeps frames from different pushes apart and still exercises full-width subtraction and addition. Random push/pop round trips run on random contexts, mixed with these directed cases:
- misaligned stack pointers;
- an accept pulse and a return pulse in the same cycle;
- requests held high while a sequence is running;
- a stack pointer of zero, where sp−8 wraps around the top of the address space.

// File: rtl/irq_frame_stacker.sv
module irq_frame_stacker #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic              reti_i,
  input  logic [31:0]       pc_i,
  input  logic [15:0]       psw_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              push_done_o,
  output logic              pop_done_o,
  output logic              align_err_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [31:0]       pc_o,
  output logic [15:0]       psw_o
);
  localparam logic [ADDR_W-1:0] FRAME = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] WORD  = ADDR_W'(4);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_RLO, S_RHI, S_PUSHED, S_POPPED, S_ERR} state_t;

  state_t            state;
  logic [ADDR_W-1:0] base;
  logic [31:0]       pc_q;
  logic [15:0]       psw_q;
  logic              start, misaligned;

  assign start      = (state == S_IDLE) && (accept_i || reti_i);
  assign misaligned = sp_i[1:0] != 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      base  <= '0;
      pc_q  <= '0;
      psw_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          if (misaligned)    state <= S_ERR;
          else if (accept_i) begin
            state <= S_WLO;
            base  <= sp_i - FRAME;
            pc_q  <= pc_i;
            psw_q <= psw_i;
          end else begin
            state <= S_RLO;
            base  <= sp_i;
          end
        end
        S_WLO: state <= S_WHI;
        S_WHI: state <= S_PUSHED;
        S_RLO: begin
          psw_q <= mem_rdata_i[15:0];
          state <= S_RHI;
        end
        S_RHI: begin
          pc_q  <= mem_rdata_i;
          state <= S_POPPED;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_we_o    = (state == S_WLO) || (state == S_WHI);
  assign mem_re_o    = (state == S_RLO) || (state == S_RHI);
  assign mem_addr_o  = ((state == S_WHI) || (state == S_RHI)) ? base + WORD : base;
  assign mem_wdata_o = (state == S_WLO) ? {16'h0000, psw_q} : pc_q;
  assign push_done_o = state == S_PUSHED;
  assign pop_done_o  = state == S_POPPED;
  assign align_err_o = state == S_ERR;
  assign sp_o        = pop_done_o ? base + FRAME : base;
  assign pc_o        = pc_q;
  assign psw_o       = psw_q;

  // R10
  aligned_access_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we_o || mem_re_o) |-> (mem_addr_o[1:0] == 2'b00 && !(mem_we_o && mem_re_o)));

  // R3
  two_writes_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_o) |=> (mem_we_o && mem_addr_o == $past(mem_addr_o) + WORD));

  // R4
  push_done_chk: assert property (@(posedge clk) disable iff (rst)
    push_done_o |-> ($past(mem_we_o) && sp_o[1:0] == 2'b00 && sp_o + WORD == $past(mem_addr_o)));

  // R5
  misalign_chk: assert property (@(posedge clk) disable iff (rst)
    (start && misaligned) |=> (align_err_o && !mem_we_o && !mem_re_o));

  // R7
  pop_done_chk: assert property (@(posedge clk) disable iff (rst)
    pop_done_o |-> ($past(mem_re_o) && sp_o == $past(mem_addr_o) + WORD));

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push_done_o, pop_done_o, align_err_o}));
endmodule

// File: tb/irq_frame_stacker_tb.sv
module irq_frame_stacker_tb;
  localparam int AW = 32;
  logic clk = 0, rst = 1;
  logic accept = 0, reti = 0;
  logic [31:0] pc = 0;
  logic [15:0] psw = 0;
  logic [AW-1:0] sp = 0;
  logic we, re, pdone, qdone, aerr;
  logic [AW-1:0] addr, spo;
  logic [31:0] wdata, rdata, pco;
  logic [15:0] pswo;
  logic [31:0] mem [1024];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  irq_frame_stacker #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .accept_i(accept), .reti_i(reti), .pc_i(pc), .psw_i(psw),
    .sp_i(sp), .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata), .push_done_o(pdone), .pop_done_o(qdone), .align_err_o(aerr),
    .sp_o(spo), .pc_o(pco), .psw_o(pswo));

  assign rdata = mem[addr[11:2]];
  always @(posedge clk) if (we) mem[addr[11:2]] <= wdata;

  function automatic logic [31:0] lo_word(input logic [15:0] p);
    return {16'h0000, p};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] p, input logic [15:0] s, input logic [AW-1:0] spv,
                      input bit hold, input bit both);
    pc = p; psw = s; sp = spv; accept = 1; reti = both;
    @(negedge clk);
    accept = hold; reti = hold;
    chk("R2 we", {63'b0, we}, 64'd1);
    chk("R2 addr", {32'b0, addr}, {32'b0, spv - 32'd8});
    chk("R2 data", {32'b0, wdata}, {32'b0, lo_word(s)});
    chk("R9/R10 no read", {63'b0, re}, 64'd0);
    @(negedge clk);
    accept = 0; reti = 0;
    chk("R3 we", {63'b0, we}, 64'd1);
    chk("R3 addr", {32'b0, addr}, {32'b0, spv - 32'd4});
    chk("R3 data", {32'b0, wdata}, {32'b0, p});
    @(negedge clk);
    chk("R4 done", {61'b0, pdone, qdone, we}, 64'b100);
    chk("R4 sp", {32'b0, spo}, {32'b0, spv - 32'd8});
    @(negedge clk);
    chk("R8 idle after push", {60'b0, we, re, pdone, qdone}, 64'd0);
  endtask

  task automatic pop(input logic [AW-1:0] spv, input logic [31:0] ep, input logic [15:0] es,
                     input bit hold);
    sp = spv; reti = 1;
    @(negedge clk);
    reti = hold; accept = hold;
    chk("R6 first read", {31'b0, re, addr}, {31'b0, 1'b1, spv});
    chk("R6 no write", {63'b0, we}, 64'd0);
    @(negedge clk);
    reti = 0; accept = 0;
    chk("R6 second read", {31'b0, re, addr}, {31'b0, 1'b1, spv + 32'd4});
    @(negedge clk);
    chk("R7 done", {62'b0, pdone, qdone}, 64'b01);
    chk("R7 pc", {32'b0, pco}, {32'b0, ep});
    chk("R7 psw", {48'b0, pswo}, {48'b0, es});
    chk("R7 sp", {32'b0, spo}, {32'b0, spv + 32'd8});
    @(negedge clk);
    chk("R8 idle after pop", {60'b0, we, re, pdone, qdone}, 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rp;
    logic [15:0] rs;
    logic [AW-1:0] rsp;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | i;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {59'b0, we, re, pdone, qdone, aerr}, 64'd0);
    rst = 0;
    @(negedge clk);
    chk("R1 idle", {59'b0, we, re, pdone, qdone, aerr}, 64'd0);

    push(32'h1234_5678, 16'hA5C3, 32'h0000_0800, 0, 0);
    pop(32'h0000_07F8, 32'h1234_5678, 16'hA5C3, 0);
    chk("R2 reserved zero", {32'b0, mem[(32'h7F8 >> 2)]}, {32'b0, 32'h0000_A5C3});

    // R9
    push(32'hCAFE_0001, 16'h0F0F, 32'h0000_0400, 0, 1);
    // R8
    push(32'h0BAD_F00D, 16'h1111, 32'h0000_0600, 1, 0);
    pop(32'h0000_05F8, 32'h0BAD_F00D, 16'h1111, 1);

    for (int k = 1; k < 4; k++) begin
      sp = 32'h0000_0300 | k; accept = (k != 2); reti = (k == 2);
      @(negedge clk);
      accept = 0; reti = 0;
      chk("R5 err", {61'b0, aerr, we, re}, 64'b100);
      @(negedge clk);
      chk("R5 quiet", {60'b0, aerr, we, re, pdone | qdone}, 64'd0);
    end

    // wrap: sp 0 -> frame at top of address space, memory window wraps too
    push(32'hFFFF_0000, 16'h8001, 32'h0000_0000, 0, 0);
    pop(32'hFFFF_FFF8, 32'hFFFF_0000, 16'h8001, 0);

    for (int n = 0; n < 200; n++) begin
      rp = $urandom; rs = 16'($urandom);
      rsp = 32'h100 + ((32'($urandom) % 32'd700) << 2);
      push(rp, rs, rsp, 1'($urandom), 1'($urandom));
      if ($urandom % 3 == 0) repeat ($urandom % 3) @(negedge clk);
      pop(rsp - 32'd8, rp, rs, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule